// File: doc/BRIEF.md
# Vertical-Sync-Clocked Identification Streamer

This block is the display-side sender of a one-way identification link. It reads a fixed 128-byte identification table and sends it on a single serial data line, one bit per vertical sync pulse, over and over. The host never sends a request or an acknowledge, and there is no separate clock line. The host recovers bit timing from the vertical sync it generates itself, so the line runs at roughly 60 to 100 bits per second.

Vertical sync comes from outside the system clock domain. It passes through a two-flop synchroniser, and each rising edge becomes a one-cycle advance strobe. A byte takes nine strobes: eight data bits, most significant first, then one high separator bit. The block reads the table through a byte-wide port with one cycle of registered read latency. The address is held on the current byte index, so the data is ready well before its first bit goes out. When the enable is low, the line idles high and the position returns to the start of byte 0.

Top module: `vsync_id_streamer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sdata_out` is 1 and `mem_addr` is 0.
- R2: A rising edge on `vsync_in` updates `sdata_out` at the third rising clock edge after `vsync_in` is first sampled high, and not earlier. `sdata_out` changes only on an advance or when the block is disabled.
- R3: The first eight advances of each byte send the table byte most significant bit first (bit 7 down to bit 0).
- R4: The ninth advance of each byte sends a 1 as the separator, and the next advance starts the next byte.
- R5: Bytes go out in index order 0, 1, ..., 127, then wrap to byte 0 with no extra bit periods.
- R6: While `enable` is 0, `sdata_out` is 1 from the next clock on, `mem_addr` is 0, and vsync edges have no effect. After `enable` returns to 1, sending restarts at byte 0, bit 7.
- R7: A vsync pulse held high for many clock cycles advances the stream by exactly one bit.
- R8: `mem_addr` equals the index of the byte being sent. It changes only on the advance that sends a separator, stepping by +1 or wrapping from 127 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_in | input | 1 | Vertical sync, asynchronous to clk; each rising edge is one bit period |
| enable | input | 1 | 1 streams the table; 0 idles the line high and rewinds to byte 0 |
| mem_addr | output | 7 | Read address into the identification table (registered) |
| mem_rdata | input | 8 | Table byte, valid one clock after `mem_addr` |
| sdata_out | output | 1 | Serial identification data, registered |

## Verification
The streaming pass uses table bytes chosen to expose bit-order and framing faults. Alternating patterns (5A, A5) catch reversed bit order. All-ones and all-zeros bytes show whether the separator is inserted or merged into the data. Single-bit bytes (80, 01) show whether the first or last data bit is lost. The run covers all 128 bytes and then byte 0 again, which separates a correct wrap from an off-by-one byte count. A vsync pulse held high for 30 cycles shows whether the stream advances once or several times. A disable in the middle of a byte shows whether the block restarts from byte 0 rather than resuming. Exact-cycle sampling around an edge pins the latency of the synchroniser.

// File: rtl/vsid_pkg.sv
package vsid_pkg;
  localparam int TABLE_BYTES = 128;
  localparam int BYTE_W      = 8;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/vsid_edge_det.sv
module vsid_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  // chain[0..STAGES-1] synchronise, chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= async_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/vsid_frame_ctr.sv
module vsid_frame_ctr #(
  parameter int NBYTES = 128,
  parameter int WORD_W = 8,
  localparam int AW    = $clog2(NBYTES),
  localparam int BW    = $clog2(WORD_W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [BW-1:0] bit_idx,
  output logic [AW-1:0] byte_idx
);
  localparam logic [BW-1:0] SEP_POS  = BW'(WORD_W);
  localparam logic [AW-1:0] LAST_IDX = AW'(NBYTES - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (adv) begin
      if (bit_idx == SEP_POS) begin
        bit_idx  <= '0;
        byte_idx <= (byte_idx == LAST_IDX) ? '0 : byte_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= SEP_POS);

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(byte_idx) |-> (byte_idx == $past(byte_idx) + 1'b1) || (byte_idx == '0));

  // R8
  addr_on_sep_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && bit_idx != SEP_POS) |=> $stable(byte_idx));
endmodule

// File: rtl/vsid_bit_out.sv
module vsid_bit_out #(
  parameter int WORD_W = 8,
  localparam int BW    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  input  logic [BW-1:0]     bit_idx,
  input  logic [WORD_W-1:0] rdata,
  output logic              sdata
);
  localparam logic [BW-1:0] SEP_POS = BW'(WORD_W);

  logic [WORD_W-1:0] shifted;
  logic              next_bit;

  always_comb begin
    shifted  = rdata << bit_idx;
    next_bit = (bit_idx == SEP_POS) ? 1'b1 : shifted[WORD_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  sdata <= 1'b1;
    else if (adv)    sdata <= next_bit;
  end

  // R2
  change_needs_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> ($past(adv) || $past(clr)));
endmodule

// File: rtl/vsync_id_streamer.sv
module vsync_id_streamer #(
  parameter int BLOCK_BYTES = vsid_pkg::TABLE_BYTES,
  parameter int WORD_W      = vsid_pkg::BYTE_W,
  parameter int SYNC_DEPTH  = vsid_pkg::SYNC_STAGES,
  localparam int AW         = $clog2(BLOCK_BYTES),
  localparam int BW         = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync_in,
  input  logic              enable,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              sdata_out
);
  logic          vs_rise;
  logic          adv;
  logic          clr;
  logic [BW-1:0] bit_idx;
  logic [AW-1:0] byte_idx;

  assign clr = ~enable;
  assign adv = vs_rise & enable;

  vsid_edge_det #(.STAGES(SYNC_DEPTH)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .async_in (vsync_in),
    .rise     (vs_rise)
  );

  vsid_frame_ctr #(.NBYTES(BLOCK_BYTES), .WORD_W(WORD_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .adv      (adv),
    .bit_idx  (bit_idx),
    .byte_idx (byte_idx)
  );

  vsid_bit_out #(.WORD_W(WORD_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .adv     (adv),
    .bit_idx (bit_idx),
    .rdata   (mem_rdata),
    .sdata   (sdata_out)
  );

  // address held on the byte in flight; the table's registered read settles long before the next strobe
  assign mem_addr = byte_idx;

  // R6
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (sdata_out && mem_addr == '0));
endmodule

// File: tb/vsync_id_streamer_tb.sv
module vsync_id_streamer_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] TBL [8] = '{8'h5A, 8'h3C, 8'hFF, 8'h00,
                                     8'h80, 8'h01, 8'hA5, 8'hC3};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vsync_in = 1'b0;
  logic       enable = 1'b1;
  logic [6:0] mem_addr;
  logic [7:0] mem_rdata;
  logic       sdata_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vsync_id_streamer u_dut (
    .clk(clk), .rst(rst), .vsync_in(vsync_in), .enable(enable),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .sdata_out(sdata_out)
  );

  function automatic logic [7:0] tbl_byte(input int i);
    if (i < 8) return TBL[i];
    return 8'((i * 29 + 7) ^ (i << 3));
  endfunction

  always_ff @(posedge clk) mem_rdata <= tbl_byte(int'(mem_addr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(output logic b);
    @(negedge clk) vsync_in = 1'b1;
    repeat (4) @(negedge clk);
    vsync_in = 1'b0;
    repeat (4) @(negedge clk);
    b = sdata_out;
  endtask

  task automatic recv(input int n, output logic [8:0] v);
    logic b;
    v = '0;
    for (int k = 0; k < n; k++) begin
      pulse(b);
      v = {v[7:0], b};
    end
  endtask

  initial begin
    logic [8:0] v;
    logic       b;
    repeat (3) @(negedge clk);
    // R1
    chk(sdata_out == 1'b1, "R1 sdata in reset", sdata_out, 1);
    chk(mem_addr == 7'd0, "R1 addr in reset", mem_addr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sdata_out == 1'b1 && mem_addr == 7'd0, "R1 after release", {mem_addr, sdata_out}, 1);

    // R3 R4 R5 R8: full pass over the table
    for (int i = 0; i < 128; i++) begin
      chk(mem_addr == 7'(i), "R8 addr at byte start", mem_addr, i);
      recv(9, v);
      chk(v == {tbl_byte(i), 1'b1}, (i < 8) ? "R3/R4 table byte" : "R5 byte order", v, {tbl_byte(i), 1'b1});
    end
    chk(mem_addr == 7'd0, "R5 wrap addr", mem_addr, 0);
    recv(9, v);
    chk(v == {TBL[0], 1'b1}, "R5 wrap byte0", v, {TBL[0], 1'b1});

    // R7: long vsync high, one advance only
    @(negedge clk) vsync_in = 1'b1;
    repeat (30) @(negedge clk);
    vsync_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(sdata_out == TBL[1][7], "R7 first bit after hold", sdata_out, TBL[1][7]);
    recv(8, v);
    chk(v[7:0] == {TBL[1][6:0], 1'b1}, "R7 single advance", v[7:0], {TBL[1][6:0], 1'b1});

    // R6: disable mid byte
    recv(3, v);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk(sdata_out == 1'b1, "R6 idle high", sdata_out, 1);
    chk(mem_addr == 7'd0, "R6 addr rewound", mem_addr, 0);
    pulse(b);
    chk(b == 1'b1 && mem_addr == 7'd0, "R6 vsync ignored", {mem_addr, b}, 1);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    recv(9, v);
    chk(v == {TBL[0], 1'b1}, "R6 restart at byte0", v, {TBL[0], 1'b1});

    // R2: exact latency on byte1 MSB (0 after separator 1)
    @(negedge clk) vsync_in = 1'b1;
    @(negedge clk);
    chk(sdata_out == 1'b1, "R2 no change at edge 1", sdata_out, 1);
    @(negedge clk);
    chk(sdata_out == 1'b1, "R2 no change at edge 2", sdata_out, 1);
    @(negedge clk);
    chk(sdata_out == TBL[1][7], "R2 change at edge 3", sdata_out, TBL[1][7]);
    vsync_in = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule